// File: doc/BRIEF.md
# Video Raster Timing Generator

This block produces the sync and blanking pattern of one programmed video mode. A host writes the active size, front porch, back porch and sync width for each axis through a simple write port, along with sync polarity, a pixel-repeat (double-scan) option and an interlace option. While video is enabled, the block walks a horizontal pixel counter and a vertical line counter through the programmed raster. From those counters it drives horizontal sync, vertical sync, data-enable, a start-of-frame pulse, a field flag and the pixel position.

Every count is written as its real value minus one. The back porch is counted from the first sync clock to the end of the line or frame, so it contains the sync pulse. In double-scan mode the host programs each horizontal quantity at twice its pixel value, and the block reports the pixel column as half the clock count.

Timing and option writes go into a pending set. The block copies the pending set into the set that drives the outputs at each frame boundary, so a frame never mixes two configurations. While video is disabled, the copy happens on every cycle.

Top module: `vrt_raster_gen`

## Requirements
- R1: After reset, video is disabled. The counters, data-enable, start-of-frame and field outputs are zero, and both syncs are high, because the reset polarity selects active-low syncs.
- R2: Write addresses are: 0 control, 1 active size, 2 back porch, 3 front porch, 4 sync width, 5 polarity. In address 0, bit 31 enables video, bit 4 selects interlace and bit 0 selects double-scan. Addresses 1 to 4 hold the vertical count in bits 16 and up and the horizontal count in bits 0 and up (AXIS_W bits each), each stored as the value minus one. In address 5, bit 1 and bit 0 make vertical sync and horizontal sync active high.
- R3: A line lasts active + front porch + back porch clocks, and a frame lasts the same sum of lines. The horizontal counter steps by one each clock, and the vertical counter steps when a line ends. Both wrap to zero.
- R4: Horizontal sync is asserted for clocks active+front to active+front+sync-1 of each line. Vertical sync is asserted for the same window of lines within the frame. The rest of the back porch follows the sync pulse.
- R5: A sync output equals its polarity bit while asserted and the inverse of that bit otherwise.
- R6: Data-enable is high only when the horizontal count is below the horizontal active size and the vertical count is below the vertical active size.
- R7: The start-of-frame output pulses for the one clock in which both counters are zero while video is enabled.
- R8: The row output equals the line count. The column output equals the clock count, or half of it (rounded down) when double-scan is active.
- R9: With interlace active, the field flag toggles at every frame boundary. Without it, the field flag is zero.
- R10: The enable bit takes effect at the clock edge that performs the write. While disabled, the counters return to zero one clock later, the position, data-enable, start-of-frame and field outputs are zero, and each sync sits at its inactive level.
- R11: While video runs, new timing, polarity, double-scan and interlace values take effect at the first clock of the next frame. While video is disabled, they take effect one clock after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| hsync_o | output | 1 | Horizontal sync at programmed polarity |
| vsync_o | output | 1 | Vertical sync at programmed polarity |
| de_o | output | 1 | Active-video data enable |
| sof_o | output | 1 | Start-of-frame pulse |
| field_o | output | 1 | Interlace field flag |
| pix_x_o | output | AXIS_W+2 | Pixel column |
| pix_y_o | output | AXIS_W+2 | Line number |

## Verification
Every output is decoded combinationally from registered state. A write therefore shows at the outputs one clock after the edge that samples it, and each free-running output changes one clock after the counter edge that drives it. The bench keeps a cycle-accurate model that updates at each rising edge, using the same pending and active sets and the same edge at which a write lands. It drives inputs on the falling edge and compares every output against the model at that falling edge, half a cycle after the state settles. Directed checks also sample at specific points to cover the deferred adoption cases: a polarity change made mid-frame must leave the current frame untouched, a mode reprogrammed while disabled must take effect one clock later, and the sync pulse must fill the whole back porch.

// File: rtl/vrt_pkg.sv
package vrt_pkg;
    parameter int unsigned AXIS_W = 12;
    localparam int unsigned CNT_W = AXIS_W + 2;

    typedef enum logic [2:0] {
        RA_CTRL = 3'd0,
        RA_ACT  = 3'd1,
        RA_BP   = 3'd2,
        RA_FP   = 3'd3,
        RA_SW   = 3'd4,
        RA_POL  = 3'd5
    } vrt_addr_e;

    // all counts held as value minus one
    typedef struct packed {
        logic [AXIS_W-1:0] h_act;
        logic [AXIS_W-1:0] h_bp;
        logic [AXIS_W-1:0] h_fp;
        logic [AXIS_W-1:0] h_sw;
        logic [AXIS_W-1:0] v_act;
        logic [AXIS_W-1:0] v_bp;
        logic [AXIS_W-1:0] v_fp;
        logic [AXIS_W-1:0] v_sw;
        logic              h_pol;
        logic              v_pol;
        logic              dbl;
        logic              ilace;
    } vrt_cfg_t;

    function automatic logic [CNT_W-1:0] axis_last(input logic [AXIS_W-1:0] act,
                                                   input logic [AXIS_W-1:0] fp,
                                                   input logic [AXIS_W-1:0] bp);
        return CNT_W'(act) + CNT_W'(fp) + CNT_W'(bp) + CNT_W'(2);
    endfunction

    function automatic logic in_sync(input logic [CNT_W-1:0] cnt,
                                     input logic [AXIS_W-1:0] act,
                                     input logic [AXIS_W-1:0] fp,
                                     input logic [AXIS_W-1:0] sw);
        logic [CNT_W-1:0] first;
        logic [CNT_W-1:0] stop;
        first = CNT_W'(act) + CNT_W'(fp) + CNT_W'(2);
        stop  = first + CNT_W'(sw) + CNT_W'(1);
        return (cnt >= first) && (cnt < stop);
    endfunction
endpackage

// File: rtl/vrt_regs.sv
module vrt_regs
    import vrt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic        frame_wrap,
    output vrt_cfg_t    act_cfg,
    output logic        video_en,
    output logic        field
);
    typedef struct packed {
        vrt_cfg_t pend;
        vrt_cfg_t act;
        logic     en;
        logic     field;
    } regs_t;

    regs_t s_d, s_q;
    logic  load;
    logic  unused_bits;

    assign unused_bits = ^wr_data;

    always_comb begin
        s_d  = s_q;
        load = !s_q.en || frame_wrap;
        if (load) begin
            s_d.act   = s_q.pend;
            s_d.field = (s_q.en && s_q.pend.ilace) ? ~s_q.field : 1'b0;
        end
        if (wr_en) begin
            case (vrt_addr_e'(wr_addr))
                RA_CTRL: begin
                    s_d.en         = wr_data[31];
                    s_d.pend.ilace = wr_data[4];
                    s_d.pend.dbl   = wr_data[0];
                end
                RA_ACT: begin
                    s_d.pend.v_act = wr_data[16 +: AXIS_W];
                    s_d.pend.h_act = wr_data[0 +: AXIS_W];
                end
                RA_BP: begin
                    s_d.pend.v_bp = wr_data[16 +: AXIS_W];
                    s_d.pend.h_bp = wr_data[0 +: AXIS_W];
                end
                RA_FP: begin
                    s_d.pend.v_fp = wr_data[16 +: AXIS_W];
                    s_d.pend.h_fp = wr_data[0 +: AXIS_W];
                end
                RA_SW: begin
                    s_d.pend.v_sw = wr_data[16 +: AXIS_W];
                    s_d.pend.h_sw = wr_data[0 +: AXIS_W];
                end
                RA_POL: begin
                    s_d.pend.v_pol = wr_data[1];
                    s_d.pend.h_pol = wr_data[0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign act_cfg  = s_q.act;
    assign video_en = s_q.en;
    assign field    = s_q.field;
endmodule

// File: rtl/vrt_axis_counter.sv
module vrt_axis_counter #(
    parameter int unsigned W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         step,
    input  logic [W-1:0] last_val,
    output logic [W-1:0] cnt,
    output logic         at_last
);
    logic [W-1:0] cnt_d, cnt_q;

    assign at_last = (cnt_q == last_val);

    always_comb begin
        cnt_d = cnt_q;
        if (!run)      cnt_d = '0;
        else if (step) cnt_d = at_last ? '0 : cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/vrt_decode.sv
module vrt_decode
    import vrt_pkg::*;
(
    input  vrt_cfg_t         cfg,
    input  logic             en,
    input  logic             field,
    input  logic [CNT_W-1:0] hcnt,
    input  logic [CNT_W-1:0] vcnt,
    output logic [CNT_W-1:0] h_last,
    output logic [CNT_W-1:0] v_last,
    output logic             hsync,
    output logic             vsync,
    output logic             de,
    output logic             sof,
    output logic             field_out,
    output logic [CNT_W-1:0] pix_x,
    output logic [CNT_W-1:0] pix_y
);
    logic hs_on, vs_on, h_vis, v_vis;

    always_comb begin
        h_last = axis_last(cfg.h_act, cfg.h_fp, cfg.h_bp);
        v_last = axis_last(cfg.v_act, cfg.v_fp, cfg.v_bp);
        hs_on  = en && in_sync(hcnt, cfg.h_act, cfg.h_fp, cfg.h_sw);
        vs_on  = en && in_sync(vcnt, cfg.v_act, cfg.v_fp, cfg.v_sw);
        h_vis  = hcnt <= CNT_W'(cfg.h_act);
        v_vis  = vcnt <= CNT_W'(cfg.v_act);
        hsync  = hs_on ? cfg.h_pol : ~cfg.h_pol;
        vsync  = vs_on ? cfg.v_pol : ~cfg.v_pol;
        de     = en && h_vis && v_vis;
        sof    = en && (hcnt == '0) && (vcnt == '0);
        field_out = en && field;
        pix_x  = !en ? '0 : (cfg.dbl ? (hcnt >> 1) : hcnt);
        pix_y  = en ? vcnt : '0;
    end
endmodule

// File: rtl/vrt_raster_gen.sv
module vrt_raster_gen
    import vrt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [31:0]      wr_data,
    output logic             hsync_o,
    output logic             vsync_o,
    output logic             de_o,
    output logic             sof_o,
    output logic             field_o,
    output logic [CNT_W-1:0] pix_x_o,
    output logic [CNT_W-1:0] pix_y_o
);
    vrt_cfg_t         cfg;
    logic             video_en;
    logic             field;
    logic [CNT_W-1:0] hcnt, vcnt, h_last, v_last;
    logic             h_end, v_end, frame_wrap;

    assign frame_wrap = video_en && h_end && v_end;

    vrt_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .frame_wrap(frame_wrap), .act_cfg(cfg),
        .video_en(video_en), .field(field)
    );

    vrt_axis_counter #(.W(CNT_W)) u_hcnt (
        .clk(clk), .rst_n(rst_n), .run(video_en), .step(1'b1),
        .last_val(h_last), .cnt(hcnt), .at_last(h_end)
    );

    vrt_axis_counter #(.W(CNT_W)) u_vcnt (
        .clk(clk), .rst_n(rst_n), .run(video_en), .step(h_end),
        .last_val(v_last), .cnt(vcnt), .at_last(v_end)
    );

    vrt_decode u_dec (
        .cfg(cfg), .en(video_en), .field(field), .hcnt(hcnt), .vcnt(vcnt),
        .h_last(h_last), .v_last(v_last), .hsync(hsync_o), .vsync(vsync_o),
        .de(de_o), .sof(sof_o), .field_out(field_o), .pix_x(pix_x_o),
        .pix_y(pix_y_o)
    );
endmodule

// File: rtl/vrt_raster_gen_chk.sv
module vrt_raster_gen_chk
    import vrt_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             video_en,
    input logic [CNT_W-1:0] hcnt,
    input logic [CNT_W-1:0] vcnt,
    input vrt_cfg_t         cfg,
    input logic             de_o,
    input logic             sof_o
);
    // R10: counters held at zero once disabled for a full clock
    a_r10_held_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!video_en && !$past(video_en)) |-> (hcnt == '0 && vcnt == '0));

    // R3: horizontal counter advances by one inside a line
    a_r3_h_step: assert property (@(posedge clk) disable iff (!rst_n)
        (video_en && hcnt != '0) |-> (hcnt == $past(hcnt) + CNT_W'(1)));

    // R7: frame start only at the raster origin
    a_r7_sof_origin: assert property (@(posedge clk) disable iff (!rst_n)
        sof_o |-> (hcnt == '0 && vcnt == '0 && de_o));

    // R11: active configuration frozen inside a running frame
    a_r11_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (video_en && $past(video_en) && !(hcnt == '0 && vcnt == '0)) |-> $stable(cfg));

    // R6: data enable only while enabled and on visible line
    a_r6_de_window: assert property (@(posedge clk) disable iff (!rst_n)
        de_o |-> (video_en && vcnt <= CNT_W'(cfg.v_act)));
endmodule

bind vrt_raster_gen vrt_raster_gen_chk u_chk (
    .clk(clk), .rst_n(rst_n), .video_en(video_en), .hcnt(hcnt), .vcnt(vcnt),
    .cfg(cfg), .de_o(de_o), .sof_o(sof_o)
);

// File: tb/vrt_raster_gen_bench.sv
module vrt_raster_gen_bench;
    import vrt_pkg::*;
    localparam int PERIOD = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [2:0]       wr_addr = '0;
    logic [31:0]      wr_data = '0;
    logic             hsync_o, vsync_o, de_o, sof_o, field_o;
    logic [CNT_W-1:0] pix_x_o, pix_y_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // model state: raw minus-one fields ha,hb,hf,hs,va,vb,vf,vs
    int p[8];
    int a[8];
    int p_pol, a_pol, p_dbl, a_dbl, p_il, a_il;
    int m_en, mh, mv, mfield;

    always #(PERIOD/2) clk = ~clk;

    vrt_raster_gen u_vrt_raster_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .sof_o(sof_o),
        .field_o(field_o), .pix_x_o(pix_x_o), .pix_y_o(pix_y_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // reference behaviour built from the requirements
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 8; i++) begin p[i] = 0; a[i] = 0; end
            p_pol = 0; a_pol = 0; p_dbl = 0; a_dbl = 0; p_il = 0; a_il = 0;
            m_en = 0; mh = 0; mv = 0; mfield = 0;
        end else begin
            int ht, vt;
            bit wrap;
            ht = a[0] + a[1] + a[2] + 3;
            vt = a[4] + a[5] + a[6] + 3;
            wrap = (m_en != 0) && mh == ht - 1 && mv == vt - 1;
            if (m_en == 0) begin mh = 0; mv = 0; end
            else if (mh == ht - 1) begin mh = 0; mv = (mv == vt - 1) ? 0 : mv + 1; end
            else mh = mh + 1;
            if (m_en == 0 || wrap) begin
                mfield = (m_en != 0 && p_il != 0) ? 1 - mfield : 0;
                for (int i = 0; i < 8; i++) a[i] = p[i];
                a_pol = p_pol; a_dbl = p_dbl; a_il = p_il;
            end
            if (wr_en) begin
                case (wr_addr)
                    3'd0: begin m_en = wr_data[31]; p_il = wr_data[4]; p_dbl = wr_data[0]; end
                    3'd1: begin p[4] = wr_data[27:16]; p[0] = wr_data[11:0]; end
                    3'd2: begin p[5] = wr_data[27:16]; p[1] = wr_data[11:0]; end
                    3'd3: begin p[6] = wr_data[27:16]; p[2] = wr_data[11:0]; end
                    3'd4: begin p[7] = wr_data[27:16]; p[3] = wr_data[11:0]; end
                    3'd5: p_pol = wr_data[1:0];
                    default: ;
                endcase
            end
        end
    end

    // continuous compare at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            bit hs, vs;
            int e_hs, e_vs, e_de, e_sof, e_x, e_y, e_f;
            hs = mh >= a[0] + a[2] + 2 && mh < a[0] + a[2] + a[3] + 3;
            vs = mv >= a[4] + a[6] + 2 && mv < a[4] + a[6] + a[7] + 3;
            e_hs = (m_en != 0 && hs) ? a_pol[0] : 1 - a_pol[0];
            e_vs = (m_en != 0 && vs) ? a_pol[1] : 1 - a_pol[1];
            e_de = (m_en != 0 && mh <= a[0] && mv <= a[4]) ? 1 : 0;
            e_sof = (m_en != 0 && mh == 0 && mv == 0) ? 1 : 0;
            e_x = (m_en == 0) ? 0 : (a_dbl != 0 ? mh / 2 : mh);
            e_y = (m_en == 0) ? 0 : mv;
            e_f = (m_en != 0 && mfield != 0) ? 1 : 0;
            chk(hsync_o == e_hs, "R4/R5 hsync", hsync_o, e_hs);
            chk(vsync_o == e_vs, "R4/R5 vsync", vsync_o, e_vs);
            chk(de_o == e_de, "R6 de", de_o, e_de);
            chk(sof_o == e_sof, "R7 sof", sof_o, e_sof);
            chk(int'(pix_x_o) == e_x, "R3/R8 pix_x", pix_x_o, e_x);
            chk(int'(pix_y_o) == e_y, "R3/R8 pix_y", pix_y_o, e_y);
            chk(field_o == e_f, "R9 field", field_o, e_f);
        end
    end

    task automatic wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = addr[2:0]; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // values passed are real counts; packed minus one per R2
    task automatic program_mode(input int ha, input int hb, input int hf, input int hs,
                                input int va, input int vb, input int vf, input int vs);
        wr(1, {4'd0, 12'(va - 1), 4'd0, 12'(ha - 1)});
        wr(2, {4'd0, 12'(vb - 1), 4'd0, 12'(hb - 1)});
        wr(3, {4'd0, 12'(vf - 1), 4'd0, 12'(hf - 1)});
        wr(4, {4'd0, 12'(vs - 1), 4'd0, 12'(hs - 1)});
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(hsync_o == 1'b1 && vsync_o == 1'b1, "R1 idle syncs", {hsync_o, vsync_o}, 3);
        chk(de_o == 0 && sof_o == 0 && field_o == 0, "R1 de/sof/field", {de_o, sof_o, field_o}, 0);
        chk(pix_x_o == 0 && pix_y_o == 0, "R1 position", pix_x_o, 0);
    endtask

    // R2 register map: 8x3 lines, fp 2, bp 4 incl sync 2; 14 clocks x 7 lines
    task automatic t_basic;
        int sofs;
        program_mode(8, 4, 2, 2, 3, 3, 1, 1);
        wr(0, 32'h8000_0000);
        chk(sof_o == 1'b1, "R10 enable takes effect", sof_o, 1);
        sofs = 0;
        for (int i = 0; i < 2 * 98; i++) begin
            @(negedge clk);
            if (sof_o) sofs++;
        end
        chk(sofs == 2, "R3 frame length 98 clocks", sofs, 2);
    endtask

    // R11 polarity change mid-frame waits for frame boundary
    task automatic t_polarity;
        while (!(pix_y_o == 1 && pix_x_o == 2)) @(negedge clk);
        wr(5, 32'h3);
        while (pix_x_o != 10) @(negedge clk);
        chk(hsync_o == 1'b0, "R11 old polarity kept in frame", hsync_o, 0);
        while (!sof_o) @(negedge clk);
        while (pix_x_o != 10) @(negedge clk);
        chk(hsync_o == 1'b1, "R11 new polarity after boundary", hsync_o, 1);
        idle(100);
    endtask

    task automatic t_dblscan;
        wr(0, 32'h8000_0001);
        while (!sof_o) @(negedge clk);
        idle(5);
        chk(pix_x_o == 2, "R8 halved column", pix_x_o, 2);
        idle(150);
    endtask

    task automatic t_interlace;
        logic f0;
        wr(0, 32'h8000_0010);
        while (!sof_o) @(negedge clk);
        f0 = field_o;
        @(negedge clk);
        while (!sof_o) @(negedge clk);
        chk(field_o != f0, "R9 field toggles", field_o, !f0);
        idle(120);
    endtask

    // R10 disable, then R11 reprogram while disabled with sync filling back porch
    task automatic t_disable;
        wr(0, 32'h0);
        idle(2);
        chk(pix_x_o == 0 && pix_y_o == 0 && de_o == 0, "R10 held at zero", pix_x_o, 0);
        chk(hsync_o == 1'b0 && vsync_o == 1'b0, "R10 inactive level (active high)", {hsync_o, vsync_o}, 0);
        program_mode(4, 2, 1, 2, 2, 2, 1, 2);
        wr(0, 32'h8000_0000);
        while (pix_x_o != 5) @(negedge clk);
        chk(hsync_o == 1'b1, "R4 sync at line end", hsync_o, 1);
        @(negedge clk);
        chk(pix_x_o == 6 && hsync_o == 1'b1, "R4 sync fills back porch", pix_x_o, 6);
        @(negedge clk);
        chk(pix_x_o == 0 && hsync_o == 1'b0, "R3 7-clock line wrap", pix_x_o, 0);
        idle(150);
    endtask

    initial begin
        fork
            begin
                #(PERIOD * 150000);
                if (!finished) begin
                    total++; bad++;
                    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
                    $display("  test done: total=%0d bad=%0d", total, bad);
                    $finish;
                end
            end
        join_none
        idle(3);
        t_reset;
        @(negedge clk) rst_n = 1'b1;
        t_reset;
        t_basic;
        t_polarity;
        t_dblscan;
        t_interlace;
        t_disable;
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule